// File: doc/BRIEF.md
# PS/2 Keyboard Frame Receiver

This block takes the clock and data lines of a PS/2 keyboard and turns each device-to-host frame into one byte in a circular receive buffer. Both lines are slow, open-collector signals. Each line goes through a two-flop synchronizer and a glitch filter. A new level must hold for `FILT_LEN` system clocks before the filtered line follows it. Every falling edge of the filtered clock samples the filtered data line.

A frame has eleven bits. The first is a start bit, which is never checked. Eight data bits follow, least significant bit first, then an odd parity bit and a stop bit. A clean frame places its data byte in the buffer. A frame with wrong parity or a low stop bit places the marker byte 0x00 instead and raises a one-cycle error pulse. A low stop bit is taken to mean that one clock edge was lost, so that sample is reused as the start bit of the next frame. If the keyboard clock stops in mid-frame for longer than `TIMEOUT_CYCLES`, the partial frame is abandoned.

The host drains the buffer through a valid/ready read stream. `rd_valid` is high whenever the buffer holds an entry. `rd_data` shows the entry at the read index. A byte is taken on any cycle where `rd_valid` and `rd_ready` are both high. While the host holds `rd_ready` low, the entry stays in place unchanged, so the host applies back-pressure simply by not accepting. The receive side cannot be stalled: a byte that arrives while the buffer is full is lost, and a sticky overflow flag is set.

Top module: `kbd_frame_rx`

## Requirements
- R1: After reset, `rd_valid` is 0, `rd_idx` and `wr_idx` are 0, `overflow` is 0 and `err_pulse` is 0.
- R2: A low pulse on the keyboard clock that is shorter than `FILT_LEN` system clocks produces no falling edge. It neither starts a frame nor shifts a bit.
- R3: A frame with correct parity and a high stop bit appends its data byte to the buffer. The data bits are taken LSB first, and the start bit is not checked. `wr_idx` grows by exactly one per appended entry.
- R4: The parity bit must make the count of ones across the 8 data bits and the parity bit odd. On a mismatch, the frame appends exactly one 0x00 entry when its stop bit is sampled, and its data is discarded.
- R5: A stop bit sampled as 0 appends one 0x00 entry. That same sample then counts as the start bit of the next frame, so the next eight falling edges are that frame's data bits.
- R6: If no filtered falling clock edge arrives for `TIMEOUT_CYCLES` system clocks while a frame is in progress, the partial frame is dropped. No entry and no error pulse result, and the next falling edge is a start bit.
- R7: `err_pulse` is high for exactly one cycle for every 0x00 error entry, and it is never high otherwise.
- R8: `rd_valid` is 1 exactly when the buffer is not empty, and `rd_data` is the entry at `rd_idx`. An entry is taken when `rd_valid` and `rd_ready` are both 1. While it is not taken, `rd_valid` stays 1 and `rd_data` holds its value.
- R9: The buffer holds 2^`ADDR_W` entries. An entry that arrives when it is full is dropped and sets `overflow`. `overflow` stays at 1 until `ovf_clear` is pulsed.
- R10: `rd_idx` and `wr_idx` are `ADDR_W` bits wide and wrap modulo 2^`ADDR_W`. When the buffer is empty, the two are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kbd_clk_i | input | 1 | Keyboard clock line (pulled up, idle high) |
| kbd_data_i | input | 1 | Keyboard data line (pulled up, idle high) |
| rd_valid | output | 1 | Buffer holds at least one entry |
| rd_ready | input | 1 | Host accepts the entry at the read index |
| rd_data | output | 8 | Entry at the read index |
| rd_idx | output | ADDR_W | Read index |
| wr_idx | output | ADDR_W | Write index |
| overflow | output | 1 | Sticky: an entry was dropped because the buffer was full |
| ovf_clear | input | 1 | Clears `overflow` |
| err_pulse | output | 1 | One-cycle pulse with each 0x00 error entry |

## Verification
The bench builds the block with `ADDR_W` = 4, which gives a 16-entry buffer. That small depth lets the full condition, the overflow drop and the index wrap all occur within a few dozen frames instead of hundreds. `TIMEOUT_CYCLES` is set to 600. This is well above the 50-cycle spacing between the bench's clock edges and well below its 1000-cycle stall, so both a healthy frame and an abandoned one are exercised. `FILT_LEN` stays at 4, so a three-cycle glitch sits just under the filter threshold.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
  typedef enum logic [0:0] {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;

  localparam logic [7:0] ERR_MARK = 8'h00;

  // Bit slots within a frame, counted after the start bit.
  localparam logic [3:0] SLOT_LAST_DATA = 4'd8;
  localparam logic [3:0] SLOT_PARITY    = 4'd9;

  // True when data plus parity carry an odd count of ones.
  function automatic logic odd_ok(input logic [7:0] d, input logic p);
    return (^d) ^ p;
  endfunction
endpackage

// File: rtl/kbd_line_filter.sv
module kbd_line_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          s1, s2;
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= 1'b1;
      s2     <= 1'b1;
      run    <= '0;
      line_o <= 1'b1;
    end else begin
      s1 <= line_i;
      s2 <= s1;
      if (s2 == line_o) begin
        run <= '0;
      end else if (run == CW'(FILT_LEN - 1)) begin
        line_o <= s2;
        run    <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/kbd_frame_fsm.sv
module kbd_frame_fsm
  import kbd_rx_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 40000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fall_i,
  input  logic       bit_i,
  output logic       push_o,
  output logic [7:0] push_data_o,
  output logic       err_o
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

  rx_state_e     state;
  logic [3:0]    slot;
  logic [7:0]    shreg;
  logic          par_bad;
  logic [TW-1:0] quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= RX_IDLE;
      slot        <= '0;
      shreg       <= '0;
      par_bad     <= 1'b0;
      quiet       <= '0;
      push_o      <= 1'b0;
      push_data_o <= '0;
      err_o       <= 1'b0;
    end else begin
      push_o <= 1'b0;
      err_o  <= 1'b0;
      if (fall_i) begin
        quiet <= '0;
        if (state == RX_IDLE) begin
          // Start bit: accepted unchecked.
          state   <= RX_BUSY;
          slot    <= 4'd1;
          par_bad <= 1'b0;
        end else if (slot <= SLOT_LAST_DATA) begin
          shreg <= {bit_i, shreg[7:1]};
          slot  <= slot + 1'b1;
        end else if (slot == SLOT_PARITY) begin
          par_bad <= !odd_ok(shreg, bit_i);
          slot    <= slot + 1'b1;
        end else begin
          push_o <= 1'b1;
          if (bit_i && !par_bad) begin
            push_data_o <= shreg;
            state       <= RX_IDLE;
          end else begin
            push_data_o <= ERR_MARK;
            err_o       <= 1'b1;
            if (!bit_i) begin
              // Low stop: reuse this sample as the next start bit.
              slot    <= 4'd1;
              par_bad <= 1'b0;
            end else begin
              state <= RX_IDLE;
            end
          end
        end
      end else if (state == RX_BUSY) begin
        if (quiet == TW'(TIMEOUT_CYCLES - 1)) begin
          state <= RX_IDLE;
          quiet <= '0;
        end else begin
          quiet <= quiet + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/kbd_code_buf.sv
module kbd_code_buf #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [7:0]        push_data_i,
  input  logic              rd_ready_i,
  input  logic              ovf_clear_i,
  output logic              rd_valid_o,
  output logic [7:0]        rd_data_o,
  output logic [ADDR_W-1:0] rd_idx_o,
  output logic [ADDR_W-1:0] wr_idx_o,
  output logic              full_o,
  output logic              overflow_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]    mem [DEPTH];
  logic [ADDR_W:0] wptr, rptr;
  logic          empty, do_wr, do_rd;

  assign empty  = (wptr == rptr);
  assign full_o = (wptr[ADDR_W] != rptr[ADDR_W]) &&
                  (wptr[ADDR_W-1:0] == rptr[ADDR_W-1:0]);
  assign do_wr  = push_i && !full_o;
  assign do_rd  = !empty && rd_ready_i;

  assign rd_valid_o = !empty;
  assign rd_data_o  = mem[rptr[ADDR_W-1:0]];
  assign rd_idx_o   = rptr[ADDR_W-1:0];
  assign wr_idx_o   = wptr[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr[ADDR_W-1:0]] <= push_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr       <= '0;
      rptr       <= '0;
      overflow_o <= 1'b0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
      if (push_i && full_o) overflow_o <= 1'b1;
      else if (ovf_clear_i) overflow_o <= 1'b0;
    end
  end
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx #(
  parameter int ADDR_W         = 8,
  parameter int FILT_LEN       = 4,
  parameter int TIMEOUT_CYCLES = 40000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kbd_clk_i,
  input  logic              kbd_data_i,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_idx,
  output logic [ADDR_W-1:0] wr_idx,
  output logic              overflow,
  input  logic              ovf_clear,
  output logic              err_pulse
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, filt;
  logic              clk_prev, fall;
  logic              push;
  logic [7:0]        push_data;
  logic              buf_full;

  assign raw = {kbd_data_i, kbd_clk_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    kbd_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .line_i(raw[g]),
      .line_o(filt[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev <= 1'b1;
    else        clk_prev <= filt[0];
  end
  assign fall = clk_prev && !filt[0];

  kbd_frame_fsm #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .fall_i     (fall),
    .bit_i      (filt[1]),
    .push_o     (push),
    .push_data_o(push_data),
    .err_o      (err_pulse)
  );

  kbd_code_buf #(.ADDR_W(ADDR_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push),
    .push_data_i(push_data),
    .rd_ready_i (rd_ready),
    .ovf_clear_i(ovf_clear),
    .rd_valid_o (rd_valid),
    .rd_data_o  (rd_data),
    .rd_idx_o   (rd_idx),
    .wr_idx_o   (wr_idx),
    .full_o     (buf_full),
    .overflow_o (overflow)
  );
endmodule

// File: rtl/kbd_frame_rx_chk.sv
module kbd_frame_rx_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [7:0]        rd_data,
  input logic [ADDR_W-1:0] rd_idx,
  input logic [ADDR_W-1:0] wr_idx,
  input logic              overflow,
  input logic              ovf_clear,
  input logic              err_pulse,
  input logic              buf_full
);
  assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_idx)));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !ovf_clear) |=> overflow);

  assert_ovf_needs_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(buf_full));

  assert_wr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_idx != $past(wr_idx)) |-> (wr_idx == ADDR_W'($past(wr_idx) + 1'b1)));

  assert_empty_idx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_idx == wr_idx));
endmodule

bind kbd_frame_rx kbd_frame_rx_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_data  (rd_data),
  .rd_idx   (rd_idx),
  .wr_idx   (wr_idx),
  .overflow (overflow),
  .ovf_clear(ovf_clear),
  .err_pulse(err_pulse),
  .buf_full (buf_full)
);

// File: tb/kbd_frame_rx_tb.sv
`timescale 1ns/1ps
module kbd_frame_rx_tb;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int H = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic kc = 1'b1, kd = 1'b1, rd_ready = 1'b0, ovf_clear = 1'b0;
  logic rd_valid, overflow, err_pulse;
  logic [7:0] rd_data;
  logic [AW-1:0] rd_idx, wr_idx;

  int tests = 0, fails = 0, errs_seen = 0, errs_exp = 0, n_written = 0;
  logic [7:0] exp_q[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  kbd_frame_rx #(.ADDR_W(AW), .FILT_LEN(4), .TIMEOUT_CYCLES(600)) u_dut (
    .clk(clk), .rst_n(rst_n), .kbd_clk_i(kc), .kbd_data_i(kd),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_idx(rd_idx), .wr_idx(wr_idx), .overflow(overflow),
    .ovf_clear(ovf_clear), .err_pulse(err_pulse)
  );

  always @(negedge clk) if (rst_n && err_pulse) errs_seen++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    kd = b; wait_n(H); kc = 1'b0; wait_n(H); kc = 1'b1;
  endtask

  // Expected parity bit: odd ones over data plus parity.
  function automatic logic par_of(input logic [7:0] v);
    return ~(^v);
  endfunction

  task automatic send_frame(input logic [7:0] v, input bit bad_par,
                            input bit bad_stop, input bit skip_start);
    if (!skip_start) send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
    send_bit(par_of(v) ^ bad_par);
    send_bit(!bad_stop);
    kd = 1'b1;
    wait_n(2 * H);
  endtask

  // Model of the buffer side: push into expected queue unless full.
  task automatic expect_entry(input logic [7:0] v);
    if (exp_q.size() < DEPTH) begin
      exp_q.push_back(v);
      n_written++;
    end
  endtask

  task automatic drain(input string tag);
    rd_ready = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 64 && rd_valid; k++) begin
      if (exp_q.size() == 0) begin
        chk(0, {tag, " extra entry"}, rd_data, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, tag, rd_data, e);
      end
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
    end
    chk(exp_q.size() == 0, {tag, " missing entries"}, exp_q.size(), 0);
    exp_q.delete();
    chk(rd_idx == wr_idx, "R10 indices equal when empty", rd_idx, wr_idx);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, hold;
    void'($urandom(32'd5150));
    wait_n(5);
    // R1: reset state
    chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
    chk(rd_idx == 0 && wr_idx == 0, "R1 indices", {rd_idx, wr_idx}, 0);
    chk(overflow == 0, "R1 overflow", overflow, 0);
    chk(err_pulse == 0, "R1 err_pulse", err_pulse, 0);
    rst_n = 1'b1;
    wait_n(10);

    // R3: directed corner bytes and random bytes
    send_frame(8'h00, 0, 0, 0); expect_entry(8'h00);
    send_frame(8'hFF, 0, 0, 0); expect_entry(8'hFF);
    send_frame(8'h01, 0, 0, 0); expect_entry(8'h01);
    send_frame(8'h80, 0, 0, 0); expect_entry(8'h80);
    drain("R3 directed");
    for (int r = 0; r < 8; r++) begin
      v = 8'($urandom);
      send_frame(v, 0, 0, 0); expect_entry(v);
    end
    drain("R3 random");
    chk(errs_seen == 0, "R7 no pulse on good frames", errs_seen, 0);

    // R4: parity error gives one 0x00 and resumes cleanly
    send_frame(8'h5A, 1, 0, 0); expect_entry(8'h00); errs_exp++;
    send_frame(8'hC3, 0, 0, 0); expect_entry(8'hC3);
    drain("R4 parity");
    chk(errs_seen == errs_exp, "R7 pulse on parity error", errs_seen, errs_exp);

    // R5: low stop reused as start of next frame
    send_frame(8'h33, 0, 1, 0); expect_entry(8'h00); errs_exp++;
    send_frame(8'hA7, 0, 0, 1); expect_entry(8'hA7);
    drain("R5 stop error");
    chk(errs_seen == errs_exp, "R7 pulse on stop error", errs_seen, errs_exp);

    // R6: stall mid-frame beyond timeout
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    kd = 1'b1; wait_n(1000);
    chk(rd_valid == 0, "R6 no entry after timeout", rd_valid, 0);
    chk(errs_seen == errs_exp, "R6 no error after timeout", errs_seen, errs_exp);
    send_frame(8'h6E, 0, 0, 0); expect_entry(8'h6E);
    drain("R6 realigned");

    // R2: sub-threshold glitches on the clock line
    kc = 1'b0; wait_n(3); kc = 1'b1; wait_n(40);
    kc = 1'b0; wait_n(2); kc = 1'b1; wait_n(40);
    chk(rd_valid == 0, "R2 glitch no entry", rd_valid, 0);
    send_frame(8'h96, 0, 0, 0); expect_entry(8'h96);
    drain("R2 after glitch");
    chk(errs_seen == errs_exp, "R2 glitch no error", errs_seen, errs_exp);

    // R8: back-pressure holds the head entry
    send_frame(8'h21, 0, 0, 0); expect_entry(8'h21);
    send_frame(8'h42, 0, 0, 0); expect_entry(8'h42);
    hold = rd_data;
    wait_n(20);
    chk(rd_valid == 1 && rd_data == hold && hold == 8'h21, "R8 stable under stall", rd_data, 8'h21);
    drain("R8 drain");

    // R9/R10: fill past capacity, wrap indices
    for (int r = 0; r < DEPTH + 1; r++) begin
      v = 8'($urandom);
      send_frame(v, 0, 0, 0); expect_entry(v);
    end
    chk(overflow == 1, "R9 overflow set", overflow, 1);
    chk(wr_idx == AW'(n_written), "R10 wr_idx wraps", wr_idx, AW'(n_written));
    drain("R9 full drain");
    chk(overflow == 1, "R9 overflow sticky", overflow, 1);
    ovf_clear = 1'b1; wait_n(1); ovf_clear = 1'b0; wait_n(1);
    chk(overflow == 0, "R9 overflow cleared", overflow, 0);
    chk(rd_idx == AW'(n_written), "R10 rd_idx wraps", rd_idx, AW'(n_written));
    chk(errs_seen == errs_exp, "R7 total pulses", errs_seen, errs_exp);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule